// File: doc/BRIEF.md
# Rotate-and-Clear-Left Execution Unit

This block decodes and runs a single 64-bit integer instruction. The instruction rotates a source value left by an amount taken from a second register, then clears the high-order bits above a chosen boundary. The unit takes a 32-bit instruction word, the two 64-bit source operands and the incoming summary-overflow bit. It returns a decode flag, the destination register index, the masked result and, in record form, a 4-bit condition-field update with its write enable.

Instruction bits are numbered big-endian, so big-endian bit k of the word is `instr[31-k]`. The mask-begin field is stored with its halves swapped, and the unit rebuilds it before use. The rotate and the mask are one combinational path between the input capture and a single output register stage.

Output timing is set by a two-state machine. `ST_IDLE` moves to `ST_PRESENT` when `in_vld` is sampled high (transition ISSUE). `ST_PRESENT` moves to `ST_PRESENT` when `in_vld` is high again (transition CHAIN), or back to `ST_IDLE` when it is low (transition DRAIN). A synchronous reset forces `ST_IDLE` (transition FLUSH).

Top module: `rotclr_exec_unit`

## Requirements
- R1: `dec_ok` is 1 only when `instr[31:26]` (big-endian bits 0–5) equals 30 and `instr[4:1]` (big-endian bits 27–30) equals 8; the word 0x78000010 decodes.
- R2: `ra_idx` on a decoded instruction equals `instr[20:16]` (big-endian bits 11–15).
- R3: The rotate amount is `rb_val[5:0]`; bits 63:6 of `rb_val` have no effect on any output.
- R4: The source `rs_val` is rotated left circularly: bits leaving the MSB re-enter at the LSB, so amount 0 returns the source unchanged and amount 63 equals a rotate right by one.
- R5: The mask-begin value MB is rebuilt as `{instr[5], instr[10:6]}`: the last bit of the 6-bit field becomes MB's MSB, and the first five bits become its low bits.
- R6: The result keeps the low 64−MB bits of the rotation and zeroes the rest; MB=0 keeps all 64 bits and MB=63 keeps only bit 0.
- R7: With `instr[0]`=1 on a decoded instruction, `cr_we` is 1 and `cr_val` = {LT, GT, EQ, SO} in bits 3..0. These flags come from a signed compare of the result with zero, and SO is a copy of `so_in`.
- R8: With `instr[0]`=0 on a decoded instruction, `cr_we` is 0.
- R9: A word that fails decode gives `dec_ok`=0, `cr_we`=0, `res`=0 and `ra_idx`=0.
- R10: `out_vld` is high in exactly the cycle after each cycle in which `in_vld` is sampled high; back-to-back issues give back-to-back results.
- R11: While `rst` is high, `out_vld`, `dec_ok` and `cr_we` are cleared at every clock edge.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Inputs are valid this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 64 | Value to rotate |
| rb_val | input | 64 | Rotate amount source (low 6 bits used) |
| so_in | input | 1 | Incoming summary-overflow bit |
| out_vld | output | 1 | Results valid |
| dec_ok | output | 1 | Instruction decoded |
| ra_idx | output | 5 | Destination register index |
| res | output | 64 | Rotated and masked result |
| cr_we | output | 1 | Condition-field write enable |
| cr_val | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The assertions assume that `in_vld` is never unknown once reset is released. They also assume that `instr`, `rs_val`, `rb_val` and `so_in` are stable around each sampling edge. The scoreboard drives every input on the falling clock edge and leaves `in_vld` either high or low, never unknown. Junk is placed only in the upper bits of `rb_val` and in opcode fields, which the requirements declare as don't-care or as rejected.

// File: rtl/rotclr_pkg.sv
package rotclr_pkg;

    localparam int RIDX_W = 5;
    localparam int MBF_W  = 6;

    typedef struct packed {
        logic              hit;
        logic [RIDX_W-1:0] ra;
        logic [MBF_W-1:0]  mb;
        logic              rec;
    } dec_fields_t;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } crf_t;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } ostate_t;

endpackage

// File: rtl/rotclr_decode.sv
module rotclr_decode
    import rotclr_pkg::*;
#(
    parameter logic [5:0] PRIM_OP = 6'd30,
    parameter logic [3:0] EXT_OP  = 4'd8
) (
    input  logic [31:0]  instr,
    output dec_fields_t  fields
);

    logic prim_match;
    logic ext_match;

    always_comb begin
        // big-endian bit k lives at instr[31-k]
        prim_match  = (instr[31:26] == PRIM_OP);
        ext_match   = (instr[4:1]   == EXT_OP);
        fields.hit  = prim_match && ext_match;
        fields.ra   = instr[20:16];
        // halves swapped: trailing field bit is the MSB of MB
        fields.mb   = {instr[5], instr[10:6]};
        fields.rec  = instr[0];
    end

endmodule

// File: rtl/rotclr_rotmask.sv
module rotclr_rotmask #(
    parameter int XLEN = 64,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] src,
    input  logic [SHW-1:0]  amt,
    input  logic [SHW-1:0]  mb,
    output logic [XLEN-1:0] res
);

    logic [XLEN-1:0] stg [0:SHW];
    logic [XLEN-1:0] keep;

    assign stg[0] = src;

    for (genvar k = 0; k < SHW; k++) begin : g_rot
        localparam int D = 1 << k;
        assign stg[k+1] = amt[k] ? {stg[k][XLEN-1-D:0], stg[k][XLEN-1:XLEN-D]}
                                 : stg[k];
    end

    // logical right shift of all ones: MB=0 leaves every bit set
    assign keep = {XLEN{1'b1}} >> mb;
    assign res  = stg[SHW] & keep;

endmodule

// File: rtl/rotclr_cond.sv
module rotclr_cond
    import rotclr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] val,
    input  logic            so_in,
    output crf_t            flags
);

    always_comb begin
        flags.lt = val[XLEN-1];
        flags.eq = ~|val;
        flags.gt = ~val[XLEN-1] & (|val);
        flags.so = so_in;
    end

endmodule

// File: rtl/rotclr_exec_unit.sv
module rotclr_exec_unit
    import rotclr_pkg::*;
#(
    parameter int         XLEN    = 64,
    parameter logic [5:0] PRIM_OP = 6'd30,
    parameter logic [3:0] EXT_OP  = 4'd8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_vld,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rb_val,
    input  logic            so_in,
    output logic            out_vld,
    output logic            dec_ok,
    output logic [4:0]      ra_idx,
    output logic [XLEN-1:0] res,
    output logic            cr_we,
    output logic [3:0]      cr_val
);

    localparam int SHW = $clog2(XLEN);

    dec_fields_t     dec;
    logic [XLEN-1:0] rot_res;
    crf_t            flags;
    ostate_t         state, nxt;

    rotclr_decode #(.PRIM_OP(PRIM_OP), .EXT_OP(EXT_OP)) u_dec (
        .instr  (instr),
        .fields (dec)
    );

    rotclr_rotmask #(.XLEN(XLEN)) u_rot (
        .src (rs_val),
        .amt (rb_val[SHW-1:0]),
        .mb  (dec.mb),
        .res (rot_res)
    );

    rotclr_cond #(.XLEN(XLEN)) u_cond (
        .val   (rot_res),
        .so_in (so_in),
        .flags (flags)
    );

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    nxt = in_vld ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: nxt = in_vld ? ST_PRESENT : ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign out_vld = (state == ST_PRESENT);

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            dec_ok <= 1'b0;
            ra_idx <= '0;
            res    <= '0;
            cr_we  <= 1'b0;
            cr_val <= '0;
        end else if (in_vld) begin
            dec_ok <= dec.hit;
            ra_idx <= dec.hit ? dec.ra : '0;
            res    <= dec.hit ? rot_res : '0;
            cr_we  <= dec.hit && dec.rec;
            cr_val <= (dec.hit && dec.rec) ? flags : '0;
        end
    end

    // R10
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    // R10
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
    // R9
    nodec_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !dec_ok) |-> (res == '0 && !cr_we && ra_idx == '0));
    // R7
    crf_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> ($countones(cr_val[3:1]) == 1));
    // R7
    crf_eq_chk: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> (cr_val[1] == (res == '0)));
    // R7
    crf_sign_chk: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> (cr_val[3] == res[XLEN-1]));
    // R8
    rec_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && dec.hit && !dec.rec) |=> !cr_we);
    // R11
    rst_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_vld && !dec_ok && !cr_we));

endmodule

// File: tb/rotclr_exec_unit_tb_top.sv
`timescale 1ns/1ps
module rotclr_exec_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] rs_val = '0;
    logic [63:0] rb_val = '0;
    logic        so_in = 1'b0;
    logic        out_vld, dec_ok, cr_we;
    logic [4:0]  ra_idx;
    logic [63:0] res;
    logic [3:0]  cr_val;

    always #2.5 clk = ~clk;

    rotclr_exec_unit dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .instr(instr),
        .rs_val(rs_val), .rb_val(rb_val), .so_in(so_in),
        .out_vld(out_vld), .dec_ok(dec_ok), .ra_idx(ra_idx),
        .res(res), .cr_we(cr_we), .cr_val(cr_val)
    );

    typedef struct {
        logic        dec;
        logic [4:0]  ra;
        logic [63:0] val;
        logic        we;
        logic [3:0]  cr;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    function automatic logic [63:0] rotl(input logic [63:0] x, input int sh);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[(i + sh) % 64] = x[i];
        return r;
    endfunction

    function automatic logic [63:0] lowmask(input int mb);
        logic [63:0] m;
        for (int i = 0; i < 64; i++) m[i] = (i < 64 - mb);
        return m;
    endfunction

    function automatic logic [31:0] enc(input logic [5:0] prim, input logic [3:0] xo,
                                        input logic [4:0] ra, input logic [5:0] mb,
                                        input logic rc);
        return {prim, 5'd7, ra, 5'd9, mb[4:0], mb[5], xo, rc};
    endfunction

    task automatic issue(input logic [31:0] iw, input logic [63:0] a,
                         input logic [63:0] b, input logic so, input string tag);
        exp_t e;
        logic hit;
        int   mb;
        logic [63:0] v;
        hit = (iw[31:26] == 6'd30) && (iw[4:1] == 4'd8);
        mb  = {iw[5], iw[10:6]};
        v   = rotl(a, int'(b[5:0])) & lowmask(mb);
        e.dec = hit;
        e.ra  = hit ? iw[20:16] : 5'd0;
        e.val = hit ? v : 64'd0;
        e.we  = hit && iw[0];
        e.cr  = e.we ? {$signed(v) < 0, $signed(v) > 0, v == 64'd0, so} : 4'd0;
        e.tag = tag;
        @(negedge clk);
        in_vld = 1'b1; instr = iw; rs_val = a; rb_val = b; so_in = so;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_vld = 1'b0;
        end
    endtask

    task automatic check(input bit ok, input string tag, input string act, input string expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", tag, act, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_vld) begin
            if (q.size() == 0) begin
                check(1'b0, "R10 unexpected out_vld", "1", "0");
            end else begin
                exp_t e;
                e = q.pop_front();
                check(dec_ok == e.dec && ra_idx == e.ra && res == e.val &&
                      cr_we == e.we && cr_val == e.cr, e.tag,
                      $sformatf("dec=%0b ra=%0d res=%h we=%0b cr=%b",
                                dec_ok, ra_idx, res, cr_we, cr_val),
                      $sformatf("dec=%0b ra=%0d res=%h we=%0b cr=%b",
                                e.dec, e.ra, e.val, e.we, e.cr));
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    localparam logic [63:0] PAT = 64'h0123_4567_89AB_CDEF;

    initial begin
        // R11: inputs active while reset held
        in_vld = 1'b1;
        instr  = enc(6'd30, 4'd8, 5'd3, 6'd0, 1'b1);
        rs_val = PAT;
        repeat (3) @(negedge clk);
        check(!out_vld && !dec_ok && !cr_we, "R11 reset clears outputs",
              $sformatf("%0b%0b%0b", out_vld, dec_ok, cr_we), "000");
        rst = 1'b0; in_vld = 1'b0;
        idle(2);

        // R1 R2 R4 R8: canonical word, rotate by 0
        issue(32'h7800_0010, PAT, 64'd0, 1'b0, "R1 R4 R8 canonical word amount 0");
        // R4: rotate by 63
        issue(enc(6'd30, 4'd8, 5'd4, 6'd0, 1'b0), PAT, 64'd63, 1'b0, "R4 amount 63");
        // R3: junk above the low 6 bits of rb_val
        issue(enc(6'd30, 4'd8, 5'd5, 6'd0, 1'b0), PAT, 64'hFFFF_FFFF_FFFF_FFC4, 1'b0, "R3 junk upper rb");
        issue(enc(6'd30, 4'd8, 5'd6, 6'd0, 1'b0), PAT, 64'hA5A5_0000_0000_0004, 1'b0, "R3 other junk upper rb");
        // R5 R6: mask boundaries
        issue(enc(6'd30, 4'd8, 5'd31, 6'd1, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, "R6 MB 1");
        issue(enc(6'd30, 4'd8, 5'd17, 6'd32, 1'b0), PAT, 64'd12, 1'b0, "R5 R6 MB 32 swapped bit");
        issue(enc(6'd30, 4'd8, 5'd2, 6'd63, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 1'b0, "R6 MB 63");
        issue(enc(6'd30, 4'd8, 5'd8, 6'd5, 1'b0), PAT, 64'd20, 1'b0, "R5 MB 5");
        issue(enc(6'd30, 4'd8, 5'd9, 6'd37, 1'b0), PAT, 64'd20, 1'b0, "R5 MB 37");
        idle(1);
        // R7: record form
        issue(enc(6'd30, 4'd8, 5'd10, 6'd0, 1'b1), 64'd0, 64'd9, 1'b0, "R7 zero result");
        issue(enc(6'd30, 4'd8, 5'd11, 6'd1, 1'b1), 64'h8000_0000_0000_0001, 64'd0, 1'b1, "R7 positive result SO");
        issue(enc(6'd30, 4'd8, 5'd12, 6'd0, 1'b1), 64'h8000_0000_0000_0001, 64'd0, 1'b0, "R7 negative result");
        issue(enc(6'd30, 4'd8, 5'd13, 6'd0, 1'b1), 64'h0000_0000_0000_0001, 64'd63, 1'b1, "R7 negative after rotate SO");
        issue(enc(6'd30, 4'd8, 5'd14, 6'd63, 1'b1), 64'hFFFF_FFFF_FFFF_FFFE, 64'd0, 1'b1, "R7 MB 63 zero");
        // R9: rejected words
        issue(enc(6'd31, 4'd8, 5'd15, 6'd0, 1'b1), PAT, 64'd3, 1'b1, "R9 R1 bad primary opcode");
        issue(enc(6'd30, 4'd9, 5'd16, 6'd0, 1'b1), PAT, 64'd3, 1'b1, "R9 R1 bad extended opcode");
        issue(enc(6'd30, 4'd0, 5'd16, 6'd0, 1'b0), PAT, 64'd3, 1'b0, "R9 R1 extended opcode 0");
        idle(3);

        // R10: nothing pending, no output strobe
        check(!out_vld, "R10 idle no strobe", $sformatf("%0b", out_vld), "0");
        check(q.size() == 0, "R10 all results delivered",
              $sformatf("%0d", q.size()), "0");
        done = 1'b1;
        summary();
        $finish;
    end

endmodule